// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block makes the bit-rate clock for a serial channel. It takes its timing from one of three sources: a tick-enable input from the chip's internal baud reference, or either of two external clock pins. An optional divide-by-16 stage follows the source. A 12-bit reload counter then divides the result by any ratio from 1 to 4096. Each time the counter runs out, the output pin changes level. At the same moment a one-cycle pulse goes to the serial channels' clock selection logic.

Everything runs on the system clock. The external pins are sampled through synchronizer flops, and each rising edge on a pin becomes a single-cycle count enable. A configuration register sets the source, the prescaler, the divisor, a run enable, a clear control and an autobaud mode. It can be rewritten in any cycle. In autobaud mode the generator stays idle until the receive data line first falls. It then starts counting from a clean phase, which helps software that is measuring an unknown line rate.

Top module: `baud_clkgen`

## Requirements
- R1: After reset, `baud_o` and `baud_tick_o` are low and the configuration register holds all zeros, so the generator stays idle until it is written.
- R2: The source field, configuration bits [14:13], selects the source: 0 is `ref_tick_i`, 1 is `pin_a_i`, 2 is `pin_b_i`. The reserved value 3 behaves like 0.
- R3: The external pins pass through two synchronizer flops. Each rising edge counts as one source tick, so a pin with a period of P cycles gives P·(N+1)·prescale system cycles between output toggles.
- R4: Configuration bit [12] sets the prescaler: 0 divides the source by 1, and 1 divides it by 16.
- R5: The divisor field, bits [11:0], holds N. The output changes level every N+1 prescaled ticks: N=0 gives 1 and N=4095 gives 4096.
- R6: When the counter runs out, `baud_o` toggles and `baud_tick_o` is high for exactly that one cycle. With `ref_tick_i` held high, a toggle never occurs without the pulse.
- R7: The configuration register accepts a write in any cycle. A new divisor written while counting first applies at the next reload, so the interval already under way completes with the old value.
- R8: The enable bit, bit [15], gates all counting. While it is 0, `baud_o` holds its level and no pulses appear.
- R9: The clear bit, bit [16], forces `baud_o` low from the next cycle and holds the counter and prescaler at zero with no pulses. After it is released with the enable bit set and `ref_tick_i` high, the first toggle comes one cycle after the release takes effect.
- R10: The autobaud bit, bit [17], holds off counting until a falling edge on `rxd_i`. With `ref_tick_i` high, a fall applied before clock edge k gives the first toggle at edge k+3. Later falls are ignored while the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 18 | Configuration value: {autobaud, clear, enable, source[1:0], prescale, divisor[11:0]} |
| ref_tick_i | input | 1 | Internal baud reference tick enable |
| pin_a_i | input | 1 | External clock pin A (asynchronous) |
| pin_b_i | input | 1 | External clock pin B (asynchronous) |
| rxd_i | input | 1 | Receive data line watched in autobaud mode (asynchronous, idles high) |
| baud_o | output | 1 | Generated baud clock to the output pin |
| baud_tick_o | output | 1 | One-cycle pulse at each toggle, for the serial channels' clock selection |

## Verification
A configuration write is captured at one clock edge and steers the counter from the next. A reference tick turns into an output toggle one edge after it is seen. A pin rising edge is first counted two edges after it is captured. A falling edge on the receive line gives its first toggle three edges after capture. The bench changes inputs on falling clock edges and reads outputs there too. It checks rates by counting the cycles between successive `baud_tick_o` pulses, which removes any start-up phase. Latency-sensitive cases such as the autobaud start, the clear release and the divisor change are counted edge by edge from the stimulus.

// File: rtl/bgen_pkg.sv
package bgen_pkg;

  localparam int DIV_W = 12;

  typedef enum logic [1:0] {
    SRC_REF   = 2'd0,
    SRC_PIN_A = 2'd1,
    SRC_PIN_B = 2'd2,
    SRC_RSVD  = 2'd3
  } src_e;

  typedef struct packed {
    logic             autobaud;
    logic             clear;
    logic             enable;
    src_e             src;
    logic             pre16;
    logic [DIV_W-1:0] divisor;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/bgen_edge_sync.sv
module bgen_edge_sync #(
  parameter int   STAGES  = 2,
  parameter bit   FALLING = 1'b0,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o
);

  localparam int QW = STAGES + 1;

  logic [QW-1:0] sync_q;
  logic [QW-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[QW-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {QW{RST_VAL}};
    end else begin
      sync_q <= sync_d;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = ~sync_q[STAGES-1] & sync_q[STAGES];
    end else begin : g_rise
      assign edge_o = sync_q[STAGES-1] & ~sync_q[STAGES];
    end
  endgenerate

endmodule

// File: rtl/bgen_prescale.sv
module bgen_prescale #(
  parameter int PRE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic restart_i,
  input  logic run_i,
  input  logic src_tick_i,
  input  logic pre16_i,
  output logic tick_o
);

  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] pcnt_d;
  logic             pcnt_en;
  logic             step;

  assign step = run_i & src_tick_i;

  always_comb begin
    pcnt_d  = pcnt_q;
    pcnt_en = 1'b0;
    if (clr_i || restart_i) begin
      pcnt_d  = '0;
      pcnt_en = 1'b1;
    end else if (step && pre16_i) begin
      pcnt_d  = pcnt_q + 1'b1;
      pcnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
    end else if (pcnt_en) begin
      pcnt_q <= pcnt_d;
    end
  end

  assign tick_o = step & ~clr_i & ~restart_i & (~pre16_i | (&pcnt_q));

endmodule

// File: rtl/bgen_divider.sv
module bgen_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             baud_o,
  output logic             pulse_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             pulse_q, pulse_d;
  logic             cnt_en;

  always_comb begin
    cnt_d   = cnt_q;
    out_d   = out_q;
    pulse_d = 1'b0;
    cnt_en  = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      out_d  = 1'b0;
      cnt_en = 1'b1;
    end else if (restart_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (tick_i) begin
      cnt_en = 1'b1;
      if (cnt_q == '0) begin
        cnt_d   = divisor_i;
        out_d   = ~out_q;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign baud_o  = out_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import bgen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             ref_tick_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             rxd_i,
  output logic             baud_o,
  output logic             baud_tick_o
);

  localparam int N_PINS = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  // Configuration register
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_t'(cfg_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q <= cfg_d;
    end
  end

  logic cfg_en, cfg_clr, cfg_ab;
  assign cfg_en  = cfg_q.enable;
  assign cfg_clr = cfg_q.clear;
  assign cfg_ab  = cfg_q.autobaud;

  // External clock pins: synchronize and detect rising edges
  logic [N_PINS-1:0] ext_pins;
  logic [N_PINS-1:0] pin_rise;

  assign ext_pins = {pin_b_i, pin_a_i};

  generate
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
      bgen_edge_sync #(
        .STAGES  (SYNC_STAGES),
        .FALLING (1'b0),
        .RST_VAL (1'b0)
      ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_n),
        .pin_i  (ext_pins[g]),
        .edge_o (pin_rise[g])
      );
    end
  endgenerate

  // Receive line: synchronize and detect falling edges (idles high)
  logic rxd_fall;

  bgen_edge_sync #(
    .STAGES  (SYNC_STAGES),
    .FALLING (1'b1),
    .RST_VAL (1'b1)
  ) u_rxd_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pin_i  (rxd_i),
    .edge_o (rxd_fall)
  );

  // Source selection
  logic src_tick;

  always_comb begin
    case (cfg_q.src)
      SRC_PIN_A: src_tick = pin_rise[0];
      SRC_PIN_B: src_tick = pin_rise[1];
      default:   src_tick = ref_tick_i;
    endcase
  end

  // Autobaud arming
  logic ab_seen_q, ab_seen_d;
  logic restart;
  logic run;

  always_comb begin
    ab_seen_d = ab_seen_q;
    if (cfg_clr || !cfg_ab) begin
      ab_seen_d = 1'b0;
    end else if (rxd_fall) begin
      ab_seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ab_seen_q <= 1'b0;
    end else begin
      ab_seen_q <= ab_seen_d;
    end
  end

  assign restart = cfg_ab & ~ab_seen_q & rxd_fall & ~cfg_clr;
  assign run     = cfg_en & ~cfg_clr & (~cfg_ab | ab_seen_q);

  // Prescaler and divider
  logic pre_tick;

  bgen_prescale #(
    .PRE_W (PRE_W)
  ) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clr_i      (cfg_clr),
    .restart_i  (restart),
    .run_i      (run),
    .src_tick_i (src_tick),
    .pre16_i    (cfg_q.pre16),
    .tick_o     (pre_tick)
  );

  bgen_divider #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (cfg_clr),
    .restart_i (restart),
    .tick_i    (pre_tick),
    .divisor_i (cfg_q.divisor),
    .baud_o    (baud_o),
    .pulse_o   (baud_tick_o)
  );

endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_o,
  input logic baud_tick_o,
  input logic cfg_en,
  input logic cfg_clr,
  input logic cfg_ab,
  input logic ab_seen_q
);

  // R6: a pulse always comes with a level change
  p_pulse_has_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> (baud_o != $past(baud_o)));

  // R6: a level change outside clear always comes with a pulse
  p_toggle_has_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((baud_o != $past(baud_o)) && !$past(cfg_clr)) |-> baud_tick_o);

  // R9: clear drives the output low on the next cycle, with no pulse
  p_clear_forces_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clr |=> (!baud_o && !baud_tick_o));

  // R8: with enable off the output level is frozen
  p_disabled_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_en && !cfg_clr) |=> $stable(baud_o));

  // R8: every pulse follows a cycle with enable on
  p_pulse_needs_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> $past(cfg_en));

  // R10: no pulse while autobaud waits for the receive line to fall
  p_autobaud_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ab && !ab_seen_q) |=> !baud_tick_o);

endmodule

bind baud_clkgen baud_clkgen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .baud_o      (baud_o),
  .baud_tick_o (baud_tick_o),
  .cfg_en      (cfg_en),
  .cfg_clr     (cfg_clr),
  .cfg_ab      (cfg_ab),
  .ab_seen_q   (ab_seen_q)
);

// File: tb/test_baud_clkgen.sv
`timescale 1ns/1ps
module test_baud_clkgen;
  import bgen_pkg::*;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             cfg_we;
  logic [CFG_W-1:0] cfg_wdata;
  logic             ref_tick;
  logic             pin_a = 1'b0;
  logic             pin_b = 1'b0;
  logic             rxd;
  logic             baud;
  logic             baud_tick;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  baud_clkgen i_baud_clkgen (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .ref_tick_i  (ref_tick),
    .pin_a_i     (pin_a),
    .pin_b_i     (pin_b),
    .rxd_i       (rxd),
    .baud_o      (baud),
    .baud_tick_o (baud_tick)
  );

  // Pin A: period 4 cycles, pin B: period 6 cycles
  initial forever begin
    repeat (2) @(negedge clk);
    pin_a = ~pin_a;
  end
  initial forever begin
    repeat (3) @(negedge clk);
    pin_b = ~pin_b;
  end

  // {src[1:0], prescale, divisor[11:0], expected cycles between pulses[15:0]}
  localparam int NV = 11;
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 1'b0, 12'd0,    16'd1},
    {2'd0, 1'b0, 12'd5,    16'd6},
    {2'd3, 1'b0, 12'd2,    16'd3},
    {2'd0, 1'b1, 12'd0,    16'd16},
    {2'd0, 1'b1, 12'd3,    16'd64},
    {2'd1, 1'b0, 12'd0,    16'd4},
    {2'd1, 1'b0, 12'd4,    16'd20},
    {2'd2, 1'b0, 12'd1,    16'd12},
    {2'd2, 1'b1, 12'd0,    16'd96},
    {2'd1, 1'b1, 12'd1,    16'd128},
    {2'd0, 1'b0, 12'd4095, 16'd4096}
  };

  function automatic logic [CFG_W-1:0] mk(input logic ab, input logic clr, input logic en,
                                         input logic [1:0] src, input logic pre,
                                         input logic [11:0] dv);
    return {ab, clr, en, src, pre, dv};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [CFG_W-1:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic measure(output int n);
    do @(negedge clk); while (!baud_tick);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int pulses;
    logic lvl;
    rst_ni    = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    ref_tick  = 1'b1;
    rxd       = 1'b1;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and idle until configured
    check("R1 baud_o after reset", int'(baud), 0);
    check("R1 baud_tick_o after reset", int'(baud_tick), 0);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (baud_tick || baud) pulses++;
    end
    check("R1 idle with reset configuration", pulses, 0);

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NV; v++) begin
      write_cfg(mk(1'b0, 1'b1, 1'b1, VEC[v][30:29], VEC[v][28], VEC[v][27:16]));
      write_cfg(mk(1'b0, 1'b0, 1'b1, VEC[v][30:29], VEC[v][28], VEC[v][27:16]));
      measure(n);
      check($sformatf("R2/R3/R4/R5 vector %0d interval", v), n, int'(VEC[v][15:0]));
    end

    // R7: divisor rewrite mid-interval applies at next reload
    write_cfg(mk(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 12'd9));
    write_cfg(mk(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 12'd9));
    do @(negedge clk); while (!baud_tick);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) begin
        cfg_we    = 1'b1;
        cfg_wdata = mk(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 12'd2);
      end else if (n == 3) begin
        cfg_we = 1'b0;
      end
    end while (!baud_tick);
    check("R7 interval in progress keeps old divisor", n, 10);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick);
    check("R7 next interval uses new divisor", n, 3);

    // R8: enable off freezes output
    write_cfg(mk(1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 12'd3));
    @(negedge clk);
    lvl = baud;
    pulses = 0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (baud_tick) pulses++;
      if (baud != lvl) n++;
    end
    check("R8 no pulses while disabled", pulses, 0);
    check("R8 level held while disabled", n, 0);

    // R9: clear forces low, release restarts from zero
    write_cfg(mk(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 12'd5));
    do @(negedge clk); while (!baud);
    write_cfg(mk(1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 12'd5));
    @(negedge clk);
    check("R9 output low after clear", int'(baud), 0);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (baud || baud_tick) pulses++;
    end
    check("R9 output held low during clear", pulses, 0);
    write_cfg(mk(1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 12'd5));
    @(negedge clk);
    check("R9 first pulse right after release", int'(baud_tick), 1);
    check("R9 output high right after release", int'(baud), 1);

    // R10: autobaud holds until rxd falls
    write_cfg(mk(1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 12'd7));
    write_cfg(mk(1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 12'd7));
    pulses = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (baud_tick) pulses++;
    end
    check("R10 no pulses before receive line falls", pulses, 0);
    rxd = 1'b0;
    pulses = 0;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      if (baud_tick) pulses++;
    end
    check("R10 no pulse before third edge after fall", pulses, 0);
    @(negedge clk);
    check("R10 first pulse at third edge after fall", int'(baud_tick), 1);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) rxd = 1'b1;
      if (n == 3) rxd = 1'b0;
    end while (!baud_tick);
    check("R10 later fall ignored, interval unchanged", n, 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule